// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-side protocol engine of a 256-byte serial EEPROM that sits on a two-wire (I2C-style) bus. It runs in a system clock that is much faster than SCL. Both bus lines pass through a two-flop synchronizer and a short glitch filter. The engine then looks for START and STOP conditions and decodes the control byte against three address-strap pins. It acknowledges by pulling SDA low, and it shifts read data out MSB first, changing the output after each SCL falling edge. A read always returns the byte at the internal address counter and then moves the counter on by one. A write first takes a word address and then up to a page of data into a 16-byte staging buffer. The low four address bits roll over inside the page, so bytes past the sixteenth overwrite earlier ones.

The staged page goes to the array only when a STOP closes the write. At that point the engine raises a one-cycle commit request that carries the page number, a byte mask and the page data. The nonvolatile array is modelled as a reset-to-0xFF register file, which the commit updates. A second control code addresses a protect register instead of the array. For that code the commit is flagged, the array is left alone, and the protect decision belongs to the logic outside this block. While an external write sequencer reports busy, control bytes get no acknowledge, so a master can poll for completion. A side read port lets the surrounding logic inspect any array byte.

Top module: `tw_eeprom_engine`

## Requirements
- R1: After reset, every array byte reads 0xFF, SDA is released (pull low output 0) and no commit is requested.
- R2: START (SDA falling while SCL high) and STOP (SDA rising while SCL high) are recognised only on filtered lines. A pulse on SDA shorter than the filter length does not count as a START or STOP. The engine ignores the bus from reset or STOP until a START arrives.
- R3: The control byte is sent MSB first as {type[3:0], A2, A1, A0, rw}. Type 4'b1010 selects the array and 4'b0110 selects the protect register. A2..A0 must equal strap_i[2:0], and rw=0 means write. Any other type, or a strap mismatch, gets no acknowledge.
- R4: The engine pulls SDA low during the ninth SCL clock after an accepted control byte, after the word address, and after every write data byte.
- R5: In a write, each data byte goes to {page, ptr}, and then the 4-bit ptr increments modulo 16 while the page (upper 4 bits) stays fixed. The commit mask marks every slot written.
- R6: Staged data reaches the array only when a STOP ends the write. A repeated START before the STOP discards the staged data, and no commit is issued.
- R7: After a write, the address counter holds the last address written, or the word address if no data byte came. Each byte sent in a read advances the counter by one, so a current read returns the byte at the counter.
- R8: In a read, a master ACK (SDA low on the ninth clock) makes the engine send the next byte, with the address wrapping from 0xFF to 0x00. A master NACK makes the engine release SDA and ignore the bus until the next START.
- R9: While busy_i is high, no control byte is acknowledged.
- R10: A write to the protect register commits with commit_prot_o=1, does not change the array and does not move the address counter. A read with the protect type gets no acknowledge.
- R11: Read data goes out MSB first, and the SDA output changes only after an SCL falling edge or a START/STOP.
- R12: peek_data_o always shows the array byte at peek_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus (wired-AND) |
| strap_i | input | 3 | Device address straps A2..A0 |
| busy_i | input | 1 | Write sequencer busy flag |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| commit_o | output | 1 | One-cycle commit request |
| commit_prot_o | output | 1 | Commit targets the protect register |
| commit_page_o | output | 4 | Page number of the staged data |
| commit_mask_o | output | 16 | Slots written in the page |
| commit_data_o | output | 128 | Staged page, slot k in bits 8k+7:8k |
| peek_addr_i | input | 8 | Side read address |
| peek_data_o | output | 8 | Array byte at peek_addr_i |

## Verification
The bench builds the engine with its defaults: 16-byte pages (PAGE_W=4) and a three-cycle glitch filter. An SCL half period of 16 system clocks leaves room to inject a one-cycle SDA spike in the middle of a high phase, and an 18-byte page write makes the in-page wrap overwrite two slots. The 8-bit address counter can be walked across 0xFF to 0x00 with a three-byte sequential read. A behavioural model holds the memory image, the address counter and the expected commits, and it predicts every ACK bit and every read byte.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  localparam logic [3:0] DEV_ARRAY = 4'b1010;
  localparam logic [3:0] DEV_PROT  = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } eng_state_e;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
  parameter int FILT_LEN = 3,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      line_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        line_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = line_q;

  // R2
  filt_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_q) |-> ($past(sync_q[1]) != $past(line_q)));
endmodule

// File: rtl/tw_page_buffer.sv
module tw_page_buffer #(
  parameter int PAGE_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       wr_i,
  input  logic [PAGE_W-1:0]          idx_i,
  input  logic [7:0]                 data_i,
  output logic [(1<<PAGE_W)-1:0]     mask_o,
  output logic [(1<<PAGE_W)*8-1:0]   data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] byte_q;
    logic       used_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        used_q <= 1'b0;
      end else if (clr_i) begin
        used_q <= 1'b0;
      end else if (wr_i && idx_i == PAGE_W'(g)) begin
        byte_q <= data_i;
        used_q <= 1'b1;
      end
    end
    assign mask_o[g]         = used_q;
    assign data_o[g*8 +: 8]  = byte_q;
  end

  // R6
  buf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_o == '0));
  // R5
  buf_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> mask_o[$past(idx_i)]);
endmodule

// File: rtl/tw_cell_array.sv
module tw_cell_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [ADDR_W-PAGE_W-1:0]        page_i,
  input  logic [(1<<PAGE_W)-1:0]          mask_i,
  input  logic [(1<<PAGE_W)*8-1:0]        data_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  output logic [7:0]                      rd_data_o,
  input  logic [ADDR_W-1:0]               pk_addr_i,
  output logic [7:0]                      pk_data_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PAGE_NUM_W = ADDR_W - PAGE_W;

  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int PG = g / PAGE_BYTES;
    localparam int SL = g % PAGE_BYTES;
    logic [7:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q <= 8'hFF;
      end else if (wr_i && page_i == PAGE_NUM_W'(PG) && mask_i[SL]) begin
        cell_q <= data_i[SL*8 +: 8];
      end
    end
    assign cells[g] = cell_q;
  end

  assign rd_data_o = cells[rd_addr_i];
  assign pk_data_o = cells[pk_addr_i];
endmodule

// File: rtl/tw_eeprom_engine.sv
module tw_eeprom_engine
  import tw_eeprom_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter int FILT_LEN = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [2:0]                 strap_i,
  input  logic                       busy_i,
  output logic                       sda_pull_o,
  output logic                       commit_o,
  output logic                       commit_prot_o,
  output logic [8-PAGE_W-1:0]        commit_page_o,
  output logic [(1<<PAGE_W)-1:0]     commit_mask_o,
  output logic [(1<<PAGE_W)*8-1:0]   commit_data_o,
  input  logic [7:0]                 peek_addr_i,
  output logic [7:0]                 peek_data_o
);
  localparam int ADDR_W     = 8;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PAGE_NUM_W = ADDR_W - PAGE_W;
  localparam int BUF_W      = PAGE_BYTES * 8;

  logic scl_f, sda_f, scl_d, sda_d;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  tw_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));
  tw_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_evt = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_evt  = scl_f & scl_d & ~sda_d & sda_f;

  eng_state_e              state_q, next_q;
  logic [3:0]              cnt_q;
  logic [7:0]              rx_q, tx_q, addr_q;
  logic [PAGE_W-1:0]       ptr_q;
  logic [PAGE_NUM_W-1:0]   page_q;
  logic                    prot_q, wr_q, more_q, pull_q;
  logic                    commit_q, commit_prot_q;

  logic                    rx_state, byte_done, pb_wr;
  logic [PAGE_BYTES-1:0]   pb_mask;
  logic [BUF_W-1:0]        pb_data;
  logic [7:0]              rd_data;
  logic [3:0]              dev_type;
  logic                    ctrl_hit;

  assign rx_state  = (state_q == ST_CTRL) || (state_q == ST_WADDR) || (state_q == ST_WDATA);
  assign byte_done = rx_state && scl_fall && (cnt_q == 4'd8);
  assign pb_wr     = byte_done && (state_q == ST_WDATA);
  assign dev_type  = rx_q[7:4];
  assign ctrl_hit  = ((dev_type == DEV_ARRAY) || (dev_type == DEV_PROT && !rx_q[0]))
                     && (rx_q[3:1] == strap_i) && !busy_i;

  tw_page_buffer #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(start_evt), .wr_i(pb_wr), .idx_i(ptr_q), .data_i(rx_q),
    .mask_o(pb_mask), .data_o(pb_data));

  tw_cell_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(commit_q && !commit_prot_q), .page_i(page_q),
    .mask_i(pb_mask), .data_i(pb_data),
    .rd_addr_i(addr_q), .rd_data_o(rd_data),
    .pk_addr_i(peek_addr_i), .pk_data_o(peek_data_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      next_q        <= ST_IDLE;
      cnt_q         <= '0;
      rx_q          <= '0;
      tx_q          <= '0;
      addr_q        <= '0;
      ptr_q         <= '0;
      page_q        <= '0;
      prot_q        <= 1'b0;
      wr_q          <= 1'b0;
      more_q        <= 1'b0;
      pull_q        <= 1'b0;
      commit_q      <= 1'b0;
      commit_prot_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (start_evt) begin
        state_q <= ST_CTRL;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
        wr_q    <= 1'b0;
      end else if (stop_evt) begin
        state_q       <= ST_IDLE;
        pull_q        <= 1'b0;
        wr_q          <= 1'b0;
        commit_q      <= wr_q && (|pb_mask);
        commit_prot_q <= prot_q;
      end else begin
        unique case (state_q)
          ST_CTRL, ST_WADDR, ST_WDATA: begin
            if (scl_rise && cnt_q != 4'd8) begin
              rx_q  <= {rx_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end
            if (byte_done) begin
              if (state_q == ST_CTRL) begin
                if (ctrl_hit) begin
                  pull_q  <= 1'b1;
                  state_q <= ST_ACK;
                  prot_q  <= (dev_type == DEV_PROT);
                  next_q  <= rx_q[0] ? ST_TX : ST_WADDR;
                  wr_q    <= !rx_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADDR) begin
                pull_q  <= 1'b1;
                state_q <= ST_ACK;
                next_q  <= ST_WDATA;
                ptr_q   <= rx_q[PAGE_W-1:0];
                page_q  <= rx_q[ADDR_W-1:PAGE_W];
                if (!prot_q) addr_q <= rx_q;
              end else begin
                pull_q  <= 1'b1;
                state_q <= ST_ACK;
                next_q  <= ST_WDATA;
                ptr_q   <= ptr_q + 1'b1;
                if (!prot_q) addr_q <= {page_q, ptr_q};
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q   <= '0;
              state_q <= next_q;
              if (next_q == ST_TX) begin
                tx_q   <= rd_data;
                pull_q <= ~rd_data[7];
              end else begin
                pull_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) cnt_q <= cnt_q + 1'b1;
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                pull_q  <= 1'b0;
                state_q <= ST_TXACK;
                addr_q  <= addr_q + 1'b1;
              end else begin
                pull_q <= ~tx_q[6];
                tx_q   <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) more_q <= ~sda_f;
            if (scl_fall) begin
              if (more_q) begin
                tx_q    <= rd_data;
                pull_q  <= ~rd_data[7];
                cnt_q   <= '0;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o    = pull_q;
  assign commit_o      = commit_q;
  assign commit_prot_o = commit_prot_q;
  assign commit_page_o = page_q;
  assign commit_mask_o = pb_mask;
  assign commit_data_o = pb_data;

  // R11
  pull_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pull_q) |-> $past(scl_fall || start_evt || stop_evt));
  // R6
  commit_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> $past(stop_evt));
  // R9
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CTRL && byte_done && busy_i) |=> !pull_q);
  // R8
  nack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TXACK && scl_fall && !more_q && !start_evt && !stop_evt)
      |=> (!pull_q && state_q == ST_IDLE));
endmodule

// File: tb/sim_tw_eeprom_engine.sv
module sim_tw_eeprom_engine;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [3:0] T_ARR = 4'b1010;
  localparam logic [3:0] T_PRT = 4'b0110;
  localparam int Q  = 8;
  localparam int HP = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         scl = 1'b1, sda_drv = 1'b1, busy = 1'b0;
  logic         sda_bus, pull, commit, commit_prot;
  logic [3:0]   commit_page;
  logic [15:0]  commit_mask;
  logic [127:0] commit_data;
  logic [7:0]   peek_addr = '0, peek_data;

  assign sda_bus = sda_drv & ~pull;

  tw_eeprom_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(STRAP), .busy_i(busy), .sda_pull_o(pull),
    .commit_o(commit), .commit_prot_o(commit_prot), .commit_page_o(commit_page),
    .commit_mask_o(commit_mask), .commit_data_o(commit_data),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data));

  int n_chk = 0, n_fail = 0, n_commit = 0, exp_commit = 0;
  logic [7:0]  mem_m [256];
  logic [7:0]  cur_m = '0;
  logic        last_prot = 1'b0;
  logic [3:0]  last_page = '0;
  logic [15:0] last_mask = '0;

  always @(negedge clk) if (commit) begin
    n_commit++;
    last_prot = commit_prot;
    last_page = commit_page;
    last_mask = commit_mask;
  end

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    tk(Q); sda_drv = 1'b1; tk(Q); scl = 1'b1; tk(HP); sda_drv = 1'b0; tk(HP); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tk(Q); sda_drv = 1'b0; tk(Q); scl = 1'b1; tk(HP); sda_drv = 1'b1; tk(HP);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      tk(Q); sda_drv = b[i]; tk(Q); scl = 1'b1;
      if (glitch && i == 7 && b[i]) begin
        tk(Q); sda_drv = 1'b0; tk(1); sda_drv = 1'b1; tk(HP - Q - 1);
      end else begin
        tk(HP);
      end
      scl = 1'b0;
    end
    tk(Q); sda_drv = 1'b1; tk(Q); scl = 1'b1; tk(HP/2);
    acked = pull;
    tk(HP/2); scl = 1'b0;
  endtask

  task automatic get_byte(input bit ack_low, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tk(Q); sda_drv = 1'b1; tk(Q); scl = 1'b1; tk(HP/2);
      b = {b[6:0], sda_bus};
      tk(HP/2); scl = 1'b0;
    end
    tk(Q); sda_drv = ~ack_low; tk(Q); scl = 1'b1; tk(HP); scl = 1'b0;
  endtask

  task automatic probe_ctrl(input logic [7:0] c, input bit exp, input string req);
    bit a;
    bus_start(); put_byte(c, 1'b0, a);
    check(a == exp, req, a, exp);
    bus_stop();
  endtask

  task automatic write_txn(input logic [3:0] dev, input logic [7:0] wa, input int n,
                           input logic [7:0] base, input bit do_stop, input bit glitch);
    bit a;
    logic [7:0]  pend [16];
    logic [15:0] pmask = '0;
    logic [3:0]  idx = wa[3:0];
    int          c0 = n_commit;
    bus_start();
    put_byte({dev, STRAP, 1'b0}, 1'b0, a); check(a, "R4 ctrl ack", a, 1);
    put_byte(wa, 1'b0, a);                  check(a, "R4 waddr ack", a, 1);
    if (dev == T_ARR) cur_m = wa;
    for (int i = 0; i < n; i++) begin
      idx = wa[3:0] + 4'(i);
      put_byte(base + 8'(i), glitch && i == 0, a);
      check(a, "R4 data ack", a, 1);
      pend[idx] = base + 8'(i);
      pmask[idx] = 1'b1;
      if (dev == T_ARR) cur_m = {wa[7:4], idx};
    end
    if (do_stop) begin
      bus_stop(); tk(4);
      if (n > 0) begin
        exp_commit++;
        check(last_mask == pmask, "R5 commit mask", last_mask, pmask);
        check(last_page == wa[7:4], "R5 commit page", last_page, wa[7:4]);
        check(last_prot == (dev == T_PRT), "R10 commit target", last_prot, dev == T_PRT);
        if (dev == T_ARR)
          for (int k = 0; k < 16; k++) if (pmask[k]) mem_m[{wa[7:4], 4'(k)}] = pend[k];
      end
      check(n_commit == exp_commit, "R6 commit count", n_commit, exp_commit);
    end else begin
      bus_start(); bus_stop(); tk(4);
      check(n_commit == c0, "R6 no commit without stop", n_commit, c0);
    end
  endtask

  task automatic read_txn(input bit random, input logic [7:0] wa, input int n, input string req);
    bit a;
    logic [7:0] got;
    if (random) begin
      bus_start();
      put_byte({T_ARR, STRAP, 1'b0}, 1'b0, a); check(a, "R4 ctrl ack", a, 1);
      put_byte(wa, 1'b0, a);                    check(a, "R4 waddr ack", a, 1);
      cur_m = wa;
    end
    bus_start();
    put_byte({T_ARR, STRAP, 1'b1}, 1'b0, a); check(a, "R4 read ctrl ack", a, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, got);
      check(got == mem_m[cur_m], req, got, mem_m[cur_m]);
      cur_m = cur_m + 8'd1;
    end
    tk(Q);
    check(pull == 1'b0, "R8 release after nack", pull, 0);
    bus_stop();
  endtask

  task automatic peek_chk(input logic [7:0] a, input string req);
    peek_addr = a; tk(1);
    check(peek_data == mem_m[a], req, peek_data, mem_m[a]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    tk(4); rst_n = 1'b1; tk(4);
    // R1 reset state
    check(pull == 1'b0, "R1 sda released", pull, 0);
    check(n_commit == 0, "R1 no commit", n_commit, 0);
    peek_chk(8'h00, "R1 array init");
    peek_chk(8'hFF, "R1 array init");

    // byte write then current reads (R7, R12)
    write_txn(T_ARR, 8'h10, 1, 8'h5A, 1'b1, 1'b0);
    peek_chk(8'h10, "R12 peek after write");
    read_txn(1'b0, 8'h00, 1, "R7 current read after write");
    read_txn(1'b0, 8'h00, 1, "R7 current read after read");

    // page write with in-page wrap (R5)
    write_txn(T_ARR, 8'h2E, 18, 8'h80, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) peek_chk(8'h20 + 8'(k), "R5 page wrap");
    read_txn(1'b0, 8'h00, 3, "R7 R11 current seq read");
    read_txn(1'b1, 8'h2E, 4, "R8 R11 random seq read");

    // counter wrap FF->00 (R8)
    write_txn(T_ARR, 8'hFF, 1, 8'h3C, 1'b1, 1'b0);
    read_txn(1'b1, 8'hFE, 3, "R8 wrap read");

    // address match (R3)
    probe_ctrl({T_ARR, 3'b100, 1'b0}, 1'b0, "R3 strap mismatch");
    probe_ctrl({4'b1011, STRAP, 1'b0}, 1'b0, "R3 bad type");
    probe_ctrl({4'b0010, STRAP, 1'b1}, 1'b0, "R3 bad type read");

    // busy polling (R9)
    busy = 1'b1;
    probe_ctrl({T_ARR, STRAP, 1'b0}, 1'b0, "R9 busy nack");
    busy = 1'b0;
    probe_ctrl({T_ARR, STRAP, 1'b0}, 1'b1, "R9 ack after busy");

    // no stop (R6)
    write_txn(T_ARR, 8'h40, 2, 8'h12, 1'b0, 1'b0);
    peek_chk(8'h40, "R6 not written");
    peek_chk(8'h41, "R6 not written");
    read_txn(1'b0, 8'h00, 1, "R7 counter after unterminated write");

    // protect register (R10)
    write_txn(T_PRT, 8'h00, 1, 8'h33, 1'b1, 1'b0);
    peek_chk(8'h00, "R10 array untouched");
    read_txn(1'b0, 8'h00, 1, "R10 counter untouched");
    probe_ctrl({T_PRT, STRAP, 1'b1}, 1'b0, "R10 protect read nack");

    // glitch on SDA while SCL high (R2)
    write_txn(T_ARR, 8'h55, 1, 8'hA5, 1'b1, 1'b1);
    peek_chk(8'h55, "R2 glitch ignored");

    tk(10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule